// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer. It starts counting on the first clock edge after reset is released. If software does not service it before its 16-bit counter wraps, it raises a one-cycle system reset request. The counter advances once every two system clock cycles. A service command reloads the counter's upper byte from an 8-bit reload input and zeros its lower byte. Software that services the timer regularly therefore sets the timeout, and software that stops servicing it gets a reset.

Software may switch the watchdog off, but only early. Right after reset there is a window in which a halt command stops the timer for good. The first service or end-of-initialisation command closes that window, and any halt command after that is ignored. A sticky cause flag tells start-up code that the last reset came from the watchdog. A watchdog-driven system reset leaves the flag set. An external hardware reset or a service command clears it.

Top module: `guarded_watchdog`

## Requirements
- R1: While either reset is high, the counter is held at 0x0000, the prescaler is cleared, the disable window is open and `wdt_reset_req` is 0. A hardware reset also drives `wdt_cause` to 0.
- R2: Counting starts on the first clock edge with both resets low. The counter then advances by one on every second clock edge.
- R3: After reset the counter starts from reload byte 0x00. With no command, the first reset request is visible right after the 131072nd clock edge following reset release.
- R4: A service command loads the counter with {`reload_val`, 0x00} and clears the prescaler. With no further command, the next request follows the service edge by (65536 − 256·`reload_val`)·2 clock edges. For example, 0xFF gives 512 and 0xFE gives 1024.
- R5: `wdt_reset_req` is high for exactly one cycle, and only after the edge where the counter wraps from 0xFFFF to 0x0000.
- R6: A counter wrap sets `wdt_cause` to 1. The flag survives `sys_rst`. It is cleared by `hw_rst` or by a service command.
- R7: A halt command stops the timer only while the window is open. Any service or init command closes the window. A halt in the same cycle as a service or init command is ignored.
- R8: Once halted, the timer issues no request until the next reset. A service command does not restart it, although it still clears `wdt_cause`.
- R9: An init command only closes the window. It leaves the counter and prescaler running unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst | input | 1 | External hardware reset, synchronous, active high; also clears the cause flag |
| sys_rst | input | 1 | Internal system reset, synchronous, active high; keeps the cause flag |
| cmd_service | input | 1 | One-cycle service command |
| cmd_halt | input | 1 | One-cycle disable command |
| cmd_init_done | input | 1 | One-cycle end-of-initialisation command |
| reload_val | input | 8 | Reload byte used by a service command |
| wdt_reset_req | output | 1 | One-cycle system reset request on overflow |
| wdt_cause | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
Some properties are checked on every cycle by the assertions:
- the request is a single-cycle pulse and always comes together with the cause flag;
- the flag rises only on a wrap and falls after a service;
- the prescaler tick never fires on two edges in a row;
- a closed or halted window never reopens, and a halted counter stays frozen;
- a service lands the reload value in the counter.

Other behaviour can only be shown by the bench scenarios:
- the exact timeout lengths, both after reset and after services with different reload bytes;
- the flag surviving a system reset but not a hardware reset;
- the halt command being refused after a service, after an init, or when it arrives in the same cycle as either;
- periodic servicing holding off the request indefinitely.

// File: rtl/gwd_pkg.sv
package gwd_pkg;

    typedef enum logic [1:0] {
        GATE_OPEN   = 2'd0,
        GATE_LOCKED = 2'd1,
        GATE_HALTED = 2'd2
    } gate_state_t;

    typedef struct packed {
        logic service;
        logic halt;
        logic init_done;
    } wdt_cmd_t;

    function automatic logic closes_window(wdt_cmd_t c);
        return c.service | c.init_done;
    endfunction

    function automatic int presc_width(int div);
        return (div > 2) ? $clog2(div) : 1;
    endfunction

endpackage

// File: rtl/gwd_prescaler.sv
module gwd_prescaler #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic clear,
    output logic tick
);
    localparam int PW = gwd_pkg::presc_width(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign tick = enable && !clear && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= '0;
        end else if (enable) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/gwd_counter.sv
module gwd_counter #(
    parameter int CNT_W    = 16,
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                advance,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload,
    output logic [CNT_W-1:0]    count,
    output logic                wrap
);
    localparam int LOW_W = CNT_W - RELOAD_W;
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] load_word;

    assign load_word = {reload, {LOW_W{1'b0}}};
    assign wrap      = !rst && !load && advance && (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_word;
        end else if (advance) begin
            count <= count + 1'b1;
        end
    end

    assert_reload_lands_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (count[LOW_W-1:0] == '0) && (count[CNT_W-1:LOW_W] == $past(reload)));

endmodule

// File: rtl/gwd_gate.sv
module gwd_gate
    import gwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wdt_cmd_t    cmd,
    output logic        running,
    output gate_state_t state
);
    gate_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_OPEN: begin
                if (closes_window(cmd))
                    state_nx = GATE_LOCKED;
                else if (cmd.halt)
                    state_nx = GATE_HALTED;
            end
            GATE_LOCKED: state_nx = GATE_LOCKED;
            GATE_HALTED: state_nx = GATE_HALTED;
            default:     state_nx = GATE_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GATE_OPEN;
        else     state <= state_nx;
    end

    assign running = (state != GATE_HALTED);

    assert_window_stays_shut_R7: assert property (@(posedge clk) disable iff (rst)
        (state == GATE_LOCKED) |=> (state == GATE_LOCKED));

    assert_halt_sticks_R8: assert property (@(posedge clk) disable iff (rst)
        (state == GATE_HALTED) |=> (state == GATE_HALTED));

    assert_mixed_halt_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (state == GATE_OPEN && cmd.halt && closes_window(cmd)) |=> (state == GATE_LOCKED));

endmodule

// File: rtl/guarded_watchdog.sv
module guarded_watchdog
    import gwd_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int RELOAD_W  = 8,
    parameter int PRESC_DIV = 2
) (
    input  logic                clk,
    input  logic                hw_rst,
    input  logic                sys_rst,
    input  logic                cmd_service,
    input  logic                cmd_halt,
    input  logic                cmd_init_done,
    input  logic [RELOAD_W-1:0] reload_val,
    output logic                wdt_reset_req,
    output logic                wdt_cause
);
    logic        any_rst;
    wdt_cmd_t    cmd;
    logic        running;
    gate_state_t gate_state;
    logic        tick;
    logic        wrap;
    logic [CNT_W-1:0] count;

    assign any_rst = hw_rst | sys_rst;
    assign cmd     = '{service: cmd_service, halt: cmd_halt, init_done: cmd_init_done};

    gwd_gate u_gate (
        .clk     (clk),
        .rst     (any_rst),
        .cmd     (cmd),
        .running (running),
        .state   (gate_state)
    );

    gwd_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk    (clk),
        .rst    (any_rst),
        .enable (running),
        .clear  (cmd.service),
        .tick   (tick)
    );

    gwd_counter #(.CNT_W(CNT_W), .RELOAD_W(RELOAD_W)) u_cnt (
        .clk     (clk),
        .rst     (any_rst),
        .advance (tick),
        .load    (cmd.service),
        .reload  (reload_val),
        .count   (count),
        .wrap    (wrap)
    );

    always_ff @(posedge clk) begin
        if (any_rst) wdt_reset_req <= 1'b0;
        else         wdt_reset_req <= wrap;
    end

    always_ff @(posedge clk) begin
        if (hw_rst)           wdt_cause <= 1'b0;
        else if (wrap)        wdt_cause <= 1'b1;
        else if (cmd.service) wdt_cause <= 1'b0;
    end

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (any_rst)
        wdt_reset_req |=> !wdt_reset_req);

    assert_pulse_flags_cause_R6: assert property (@(posedge clk) disable iff (any_rst)
        wdt_reset_req |-> wdt_cause);

    assert_cause_rise_from_wrap_R6: assert property (@(posedge clk) disable iff (hw_rst)
        $rose(wdt_cause) |-> $past(wrap));

    assert_service_clears_cause_R6: assert property (@(posedge clk) disable iff (any_rst)
        (cmd.service && !wrap) |=> !wdt_cause);

    assert_halted_frozen_R8: assert property (@(posedge clk) disable iff (any_rst)
        (gate_state == GATE_HALTED && !cmd.service) |=> $stable(count) && !wdt_reset_req);

endmodule

// File: tb/guarded_watchdog_test.sv
module guarded_watchdog_test;
    logic       clk = 1'b0;
    logic       hw_rst = 1'b1;
    logic       sys_rst = 1'b0;
    logic       cmd_service = 1'b0;
    logic       cmd_halt = 1'b0;
    logic       cmd_init_done = 1'b0;
    logic [7:0] reload_val = 8'h00;
    logic       wdt_reset_req;
    logic       wdt_cause;

    guarded_watchdog uut (
        .clk           (clk),
        .hw_rst        (hw_rst),
        .sys_rst       (sys_rst),
        .cmd_service   (cmd_service),
        .cmd_halt      (cmd_halt),
        .cmd_init_done (cmd_init_done),
        .reload_val    (reload_val),
        .wdt_reset_req (wdt_reset_req),
        .wdt_cause     (wdt_cause)
    );

    always #4 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { longint due; string req; } exp_t;
    exp_t q[$];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected requests as the design raises them
    always @(negedge clk) begin
        if (!hw_rst && !sys_rst && wdt_reset_req) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "unexpected reset request at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.due, e.req, "request cycle", cyc, e.due);
                check(wdt_cause == 1'b1, "R6", "cause with request", wdt_cause, 1);
            end
        end
    end

    task automatic expect_req(longint due, string req);
        exp_t e;
        e.due = due;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic do_reset(bit hard, output longint base);
        @(negedge clk);
        if (hard) hw_rst = 1'b1; else sys_rst = 1'b1;
        @(negedge clk);
        check(wdt_reset_req == 1'b0, "R1", "req during reset", wdt_reset_req, 0);
        hw_rst = 1'b0;
        sys_rst = 1'b0;
        base = cyc;
    endtask

    // kind: 0 service, 1 halt, 2 init, 3 service+halt
    task automatic issue(int kind, output longint at);
        @(negedge clk);
        cmd_service   = (kind == 0 || kind == 3);
        cmd_halt      = (kind == 1 || kind == 3);
        cmd_init_done = (kind == 2);
        @(negedge clk);
        at = cyc;
        cmd_service = 1'b0;
        cmd_halt = 1'b0;
        cmd_init_done = 1'b0;
    endtask

    task automatic drain(int limit, string req);
        int k = 0;
        while (q.size() != 0 && k < limit) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        check(q.size() == 0, req, "pending requests after wait", q.size(), 0);
        q.delete();
    endtask

    task automatic quiet(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cyc, 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        longint base;
        longint t;
        longint t2;

        // R1: hardware reset state
        do_reset(1'b1, base);
        check(wdt_cause == 1'b0, "R1", "cause after hw reset", wdt_cause, 0);
        check(wdt_reset_req == 1'b0, "R1", "req after hw reset", wdt_reset_req, 0);

        // R3/R2/R9: default timeout; init closes window, later halt ignored
        expect_req(base + 131072, "R3");
        issue(2, t);
        issue(1, t);
        drain(140000, "R9");
        check(wdt_cause == 1'b1, "R6", "cause after overflow", wdt_cause, 1);

        // R6: system reset keeps the cause flag
        do_reset(1'b0, base);
        @(negedge clk);
        check(wdt_cause == 1'b1, "R6", "cause kept over sys reset", wdt_cause, 1);

        // R4: service with reload 0xFF clears cause, 512-cycle timeout
        reload_val = 8'hFF;
        issue(0, t);
        check(wdt_cause == 1'b0, "R6", "cause cleared by service", wdt_cause, 0);
        expect_req(t + 512, "R4");
        drain(700, "R4");

        // R7/R8: halt in open window stops timer; service does not restart it
        do_reset(1'b0, base);
        issue(1, t);
        quiet(1500);
        check(wdt_cause == 1'b1, "R8", "cause before service while halted", wdt_cause, 1);
        issue(0, t);
        check(wdt_cause == 1'b0, "R8", "service while halted clears cause", wdt_cause, 0);
        quiet(1500);
        check(wdt_reset_req == 1'b0, "R8", "no request while halted", wdt_reset_req, 0);

        // R7: halt together with service is refused
        do_reset(1'b0, base);
        issue(3, t);
        expect_req(t + 512, "R7");
        drain(700, "R7");

        // R7: halt after service is refused
        do_reset(1'b0, base);
        issue(0, t);
        quiet(10);
        issue(1, t2);
        expect_req(t + 512, "R7");
        drain(700, "R7");

        // R4: periodic service with reload 0xFE holds off the request
        do_reset(1'b0, base);
        reload_val = 8'hFE;
        for (int i = 0; i < 4; i++) begin
            issue(0, t);
            quiet(700);
        end
        check(wdt_reset_req == 1'b0, "R4", "no request while serviced", wdt_reset_req, 0);
        issue(0, t);
        expect_req(t + 1024, "R4");
        drain(1200, "R5");
        @(negedge clk);
        check(wdt_reset_req == 1'b0, "R5", "request lasts one cycle", wdt_reset_req, 0);

        // R1/R6: hardware reset clears cause
        check(wdt_cause == 1'b1, "R6", "cause set before hw reset", wdt_cause, 1);
        do_reset(1'b1, base);
        check(wdt_cause == 1'b0, "R1", "cause cleared by hw reset", wdt_cause, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule